// File: doc/BRIEF.md
# Batch Age Tracker for Bank Issue Fairness

This block keeps a group of pending bank requests from being starved by later traffic. At any moment it holds a "batch": one flag per bank that marks the banks which had work waiting when the batch was opened. A shared counter measures how long the batch has been waiting. When no flag is left, a new batch is opened from the current queue-occupancy vector and the counter restarts at zero.

The issue arbiter ANDs the `allowMask` output into its per-bank eligibility. While the batch is young, every bank is allowed. Once the counter passes twice the bank busy time, only banks still flagged in the batch are allowed. This lock-out lasts until the last flagged bank has issued. Starvation is therefore bounded once per batch and not once per request. The block holds no queue storage and makes no arbitration decision.

Top module: `batch_age_tracker`

## Requirements
- R1: After reset, no bank is flagged, the age counter is zero and `allowMask` is all ones.
- R2: In a cycle where no bank is flagged after that cycle's issues, the flag set becomes a copy of `queueNonEmpty` (bit i for bank i) at the clock edge, and the age counter becomes zero.
- R3: While at least one flag survives the cycle's issues, the age counter rises by exactly one per clock.
- R4: When the age counter is strictly greater than 2 × `busyTime`, `allowMask` equals the flag set. A flagged bank is allowed and an unflagged bank is blocked.
- R5: When the age counter is at most 2 × `busyTime`, `allowMask` is all ones.
- R6: A flagged bank whose `issueStb` bit is high has its flag cleared at that clock edge.
- R7: Issue and batch formation are resolved in the same cycle. When the issue of the last flagged bank empties the batch, a new batch is formed at that same edge from `queueNonEmpty`. This includes the bank that just issued, if its queue is still nonempty.
- R8: The age counter saturates at 2^(BUSY_W+2) − 1 and does not wrap. Once expired, the batch stays expired until it drains.
- R9: An `issueStb` bit for an unflagged bank has no effect on the flag set or the age counter while other flags remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| busyTime | input | BUSY_W | Bank busy time in cycles; the lock-out threshold is twice this value |
| queueNonEmpty | input | NUM_BANKS | Bit i is high when bank i has a pending request |
| issueStb | input | NUM_BANKS | Bit i pulses for one cycle when bank i issues |
| allowMask | output | NUM_BANKS | Bit i high: bank i may issue this cycle |

## Verification
Two functions can fall in the same cycle: the issue that clears the last batch flag, and the formation of the next batch. The bench provokes this by pulsing the strobe of the sole remaining flagged bank while its queue bit, and others, stay high. It judges the result by the mask after the edge, which must be all ones with a fresh counter. After a further 2 × `busyTime` + 1 cycles, the mask must equal the new set, which includes the bank that just issued. A bench-side model of flags and age, written from the requirements, gives the expected mask for every cycle of each scenario.

// File: rtl/batch_age_pkg.sv
package batch_age_pkg;
  // Command from the flag control to the age datapath.
  typedef struct packed {
    logic clearAge;  // restart the batch age at zero
    logic bumpAge;   // batch still pending: advance age (saturating)
  } ageCmd_t;
endpackage

// File: rtl/batch_age_ctrl.sv
module batch_age_ctrl
  import batch_age_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_BANKS-1:0] queueNonEmpty,
  input  logic [NUM_BANKS-1:0] issueStb,
  input  logic                 ageExpired,
  output logic [NUM_BANKS-1:0] oldFlags,
  output logic [NUM_BANKS-1:0] allowMask,
  output ageCmd_t              ageCmd
);
  logic [NUM_BANKS-1:0] survivors;
  logic                 batchDone;
  logic [NUM_BANKS-1:0] flagsNext;

  // Flags that remain once this cycle's issues are applied.
  assign survivors = oldFlags & ~issueStb;
  assign batchDone = (survivors == '0);

  always_comb begin
    if (batchDone) begin
      flagsNext = queueNonEmpty;
    end else begin
      flagsNext = survivors;
    end
  end

  always_comb begin
    ageCmd.clearAge = batchDone;
    ageCmd.bumpAge  = !batchDone;
  end

  // Per-bank gating: unflagged banks are blocked only after expiry.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    assign allowMask[b] = oldFlags[b] | ~ageExpired;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oldFlags <= '0;
    end else begin
      oldFlags <= flagsNext;
    end
  end
endmodule

// File: rtl/batch_age_dp.sv
module batch_age_dp
  import batch_age_pkg::*;
#(
  parameter int BUSY_W = 4,
  localparam int AGE_W = BUSY_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUSY_W-1:0] busyTime,
  input  ageCmd_t           ageCmd,
  output logic [AGE_W-1:0]  ageCnt,
  output logic              ageExpired
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [AGE_W-1:0] limit;

  // Twice the busy time, zero-extended into the counter width.
  assign limit      = {1'b0, busyTime, 1'b0};
  assign ageExpired = (ageCnt > limit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ageCnt <= '0;
    end else if (ageCmd.clearAge) begin
      ageCnt <= '0;
    end else if (ageCmd.bumpAge && (ageCnt != AGE_MAX)) begin
      ageCnt <= ageCnt + 1'b1;
    end
  end
endmodule

// File: rtl/batch_age_tracker.sv
module batch_age_tracker
  import batch_age_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BUSY_W    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [BUSY_W-1:0]    busyTime,
  input  logic [NUM_BANKS-1:0] queueNonEmpty,
  input  logic [NUM_BANKS-1:0] issueStb,
  output logic [NUM_BANKS-1:0] allowMask
);
  localparam int AGE_W = BUSY_W + 2;

  ageCmd_t              ageCmd;
  logic                 ageExpired;
  logic [AGE_W-1:0]     ageCnt;
  logic [NUM_BANKS-1:0] oldFlags;

  batch_age_ctrl #(.NUM_BANKS(NUM_BANKS)) uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .queueNonEmpty (queueNonEmpty),
    .issueStb      (issueStb),
    .ageExpired    (ageExpired),
    .oldFlags      (oldFlags),
    .allowMask     (allowMask),
    .ageCmd        (ageCmd)
  );

  batch_age_dp #(.BUSY_W(BUSY_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .busyTime   (busyTime),
    .ageCmd     (ageCmd),
    .ageCnt     (ageCnt),
    .ageExpired (ageExpired)
  );
endmodule

// File: rtl/batch_age_checker.sv
module batch_age_checker #(
  parameter int NUM_BANKS = 8,
  parameter int BUSY_W    = 4,
  localparam int AGE_W    = BUSY_W + 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_BANKS-1:0] queueNonEmpty,
  input logic [NUM_BANKS-1:0] issueStb,
  input logic [NUM_BANKS-1:0] allowMask,
  input logic [NUM_BANKS-1:0] oldFlags,
  input logic [AGE_W-1:0]     ageCnt
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  assert_old_allowed_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((allowMask & oldFlags) == oldFlags));

  assert_form_batch_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((oldFlags & ~issueStb) == '0) |=>
      (oldFlags == $past(queueNonEmpty)) && (ageCnt == '0));

  assert_issue_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((oldFlags & ~issueStb) != '0) |=> ((oldFlags & $past(issueStb)) == '0));

  assert_age_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (((oldFlags & ~issueStb) != '0) && (ageCnt != AGE_MAX)) |=>
      (ageCnt == $past(ageCnt) + 1'b1));

  assert_age_saturate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (((oldFlags & ~issueStb) != '0) && (ageCnt == AGE_MAX)) |=>
      (ageCnt == AGE_MAX));

  assert_no_new_flags_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((oldFlags & ~issueStb) != '0) |=> ((oldFlags & ~$past(oldFlags)) == '0));
endmodule

bind batch_age_tracker batch_age_checker #(
  .NUM_BANKS(NUM_BANKS),
  .BUSY_W   (BUSY_W)
) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .queueNonEmpty (queueNonEmpty),
  .issueStb      (issueStb),
  .allowMask     (allowMask),
  .oldFlags      (oldFlags),
  .ageCnt        (ageCnt)
);

// File: tb/batch_age_tracker_test.sv
module batch_age_tracker_test;
  localparam int NB     = 8;
  localparam int BW     = 4;
  localparam int AGEMAX = (1 << (BW + 2)) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [BW-1:0] busyTime = '0;
  logic [NB-1:0] queueNonEmpty = '0;
  logic [NB-1:0] issueStb = '0;
  logic [NB-1:0] allowMask;

  int testsRun = 0;
  int testsFailed = 0;

  // Reference model of the requirements.
  logic [NB-1:0] mOld = '0;
  int            mAge = 0;

  always #2 clk = ~clk;  // 250 MHz

  batch_age_tracker #(.NUM_BANKS(NB), .BUSY_W(BW)) uut (
    .clk(clk), .rstN(rstN), .busyTime(busyTime),
    .queueNonEmpty(queueNonEmpty), .issueStb(issueStb), .allowMask(allowMask)
  );

  function automatic logic [NB-1:0] expMask();
    if (mAge > 2 * int'(busyTime)) return mOld;
    return '1;
  endfunction

  task automatic check(input string tag, input logic [NB-1:0] exp);
    testsRun++;
    if (allowMask !== exp) begin
      testsFailed++;
      $display("FAIL %s: allowMask actual=%b expected=%b", tag, allowMask, exp);
    end
  endtask

  // One cycle: drive at negedge, update model at edge, check after it.
  task automatic step(input logic [NB-1:0] qne, input logic [NB-1:0] iss, input string tag);
    logic [NB-1:0] surv;
    @(negedge clk);
    queueNonEmpty = qne;
    issueStb = iss;
    @(posedge clk);
    surv = mOld & ~iss;
    if (surv == '0) begin
      mOld = qne;
      mAge = 0;
    end else begin
      mOld = surv;
      if (mAge < AGEMAX) mAge++;
    end
    #1;
    check(tag, expMask());
  endtask

  task automatic do_reset();
    rstN = 1'b0;
    queueNonEmpty = '0;
    issueStb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mOld = '0;
    mAge = 0;
  endtask

  task automatic t_reset();
    busyTime = 4'd3;
    do_reset();
    #1;
    check("R1 reset mask", '1);
    step('0, '0, "R1 idle after reset");
  endtask

  task automatic t_form_and_age();
    step(8'b0000_0101, '0, "R2 batch formed, mask open");
    for (int i = 0; i < 6; i++) step(8'b0000_0101, '0, "R5 young batch");
    check("R5 at threshold", '1);
    step(8'b0000_0111, '0, "R3 R4 crossed threshold");
    check("R4 only batch allowed", 8'b0000_0101);
    step(8'b0000_0111, 8'b0000_0010, "R9 unflagged issue ignored");
    check("R9 mask after stray issue", 8'b0000_0101);
    step(8'b0000_0111, 8'b0000_0001, "R6 bank0 cleared");
    check("R6 bank0 blocked", 8'b0000_0100);
  endtask

  task automatic t_same_cycle();
    // Bank2 is the last flagged bank; it issues while still nonempty.
    step(8'b0001_0110, 8'b0000_0100, "R7 drain and reform");
    check("R7 mask open after reform", '1);
    for (int i = 0; i < 7; i++) step(8'b0001_0110, '0, "R7 new batch ages");
    check("R7 new batch includes issuer", 8'b0001_0110);
  endtask

  task automatic t_saturate();
    step(8'b0001_0110, 8'b0001_0110, "R2 reform for saturation");
    busyTime = 4'd15;
    step(8'b0000_1000, 8'b0001_0110, "R2 single-bank batch");
    for (int i = 0; i < 80; i++) step(8'b1111_1111, '0, "R8 saturated age");
    check("R8 still locked after 80 cycles", 8'b0000_1000);
    step(8'b1100_0000, 8'b0000_1000, "R2 drain resets age");
    check("R2 mask open after drain", '1);
  endtask

  task automatic t_empty_batch();
    step('0, 8'b1100_0000, "R2 drain to empty");
    for (int i = 0; i < 40; i++) step('0, '0, "R5 no batch keeps mask open");
  endtask

  initial begin
    t_reset();
    t_form_and_age();
    t_same_cycle();
    t_saturate();
    t_empty_batch();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule